// File: doc/BRIEF.md
# Double-Buffered Timer Compare Channel

This block is one 16-bit compare channel that sits next to a free-running timer counter. Every cycle it checks the counter value against its active compare value and raises a match. On a timer tick it turns that match into a sticky flag. When the channel's interrupt enable is set, the flag drives an interrupt request. The flag clears when the interrupt is acknowledged, or when software writes a one to the flag's clear bit.

Software writes the compare value over an 8-bit bus. The high byte is held in a temporary byte register. The full 16-bit value is committed when the low byte is written. In the two buffered update modes the committed value lands in a buffer, and the active value is loaded from that buffer only on a timer tick at the TOP or at the BOTTOM of the count. This keeps PWM periods whole. In direct mode a commit updates the active value at once.

The active value is also driven out so that the counter can use it as its TOP (period) value. The counter, its TOP and BOTTOM strobes, and the tick enable all come from outside the block.

Top module: `ocu_channel`

## Requirements
- R1: `match_o` is high in the same cycle whenever `cnt_val` equals the active compare value, and low otherwise. It is combinational and does not depend on `tick_en`.
- R2: The flag is set by a rising clock edge at which `tick_en` and a match are both high, so it is seen one cycle later. A match without `tick_en` does not set it.
- R3: `irq_o` is high exactly when the flag is set and the interrupt enable is 1. The enable is bit 0 of a write to address 3.
- R4: A pulse on `irq_ack` clears the flag at the next edge.
- R5: A write to address 2 with bit 0 = 1 clears the flag at the next edge. A write there with bit 0 = 0 leaves the flag unchanged.
- R6: If a flag set and a clear (acknowledge or software) fall on the same edge, the flag ends up set.
- R7: In mode 1 (update at TOP), a committed write goes only to the buffer. The active value is loaded from the buffer at an edge where `tick_en` and `at_top` are both high. `at_bottom` has no effect in this mode, and neither does `at_top` without `tick_en`.
- R8: In mode 2 (update at BOTTOM), the active value is loaded from the buffer at an edge where `tick_en` and `at_bottom` are both high. `at_top` has no effect in this mode.
- R9: In mode 0 (direct, mode 3 behaves the same way), committing a write updates the active value at the next edge.
- R10: A write to address 1 stores the high byte in a temporary register and leaves the active value alone. A write to address 0 commits {temporary, data} as the new 16-bit value.
- R11: `top_val_o` always shows the active compare value.
- R12: Synchronous active-low reset clears the flag, the enable, the buffer and the active value to zero. A change on `upd_mode` is registered first, so a write in the same cycle as the change still follows the old mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Timer tick enable |
| cnt_val | input | 16 | Counter value |
| at_top | input | 1 | Counter is at TOP |
| at_bottom | input | 1 | Counter is at BOTTOM |
| upd_mode | input | 2 | 0 direct, 1 update at TOP, 2 update at BOTTOM |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write address: 0 low byte, 1 high byte, 2 flag clear, 3 control |
| wr_data | input | 8 | Write data |
| irq_ack | input | 1 | Interrupt serviced pulse |
| match_o | output | 1 | Equality of counter and active value |
| flag_o | output | 1 | Compare flag |
| irq_o | output | 1 | Interrupt request |
| top_val_o | output | 16 | Active compare value, usable as counter TOP |

## Verification
The match output is combinational, so it is checked in the same cycle its inputs are applied. The flag, interrupt request and active value are registered, so they are due one edge after the stimulus. Buffered loads are likewise due one edge after the tick that carries the TOP or BOTTOM strobe. Each expectation the driver queues carries the cycle number on which it is due. Inputs change just after a rising edge, and the monitor compares each item at the falling edge of its due cycle.

// File: rtl/ocu_pkg.sv
// Shared encodings for the compare channel: update modes and write addresses.
package ocu_pkg;
    typedef enum logic [1:0] {
        UPD_DIRECT    = 2'd0,
        UPD_AT_TOP    = 2'd1,
        UPD_AT_BOTTOM = 2'd2,
        UPD_DIRECT_B  = 2'd3
    } upd_mode_e;

    localparam logic [1:0] ADR_LO   = 2'd0;
    localparam logic [1:0] ADR_HI   = 2'd1;
    localparam logic [1:0] ADR_FLAG = 2'd2;
    localparam logic [1:0] ADR_CTRL = 2'd3;
endpackage

// File: rtl/ocu_compare.sv
// Equality comparator between counter value and active compare value.
// Assumes both operands are the same width; purely combinational.
module ocu_compare #(
    parameter int CMP_W = 16
) (
    input  logic [CMP_W-1:0] cnt_i,
    input  logic [CMP_W-1:0] ref_i,
    output logic             eq_o
);
    // Combinational equality decision.
    always_comb begin
        eq_o = (cnt_i == ref_i);
    end
endmodule

// File: rtl/ocu_regfile.sv
// Holds the temporary high byte, the write buffer, the active compare value,
// the registered update mode and the interrupt enable.
// Assumes byte writes arrive one per cycle on wr_en; reset is synchronous active-low.
module ocu_regfile
    import ocu_pkg::*;
#(
    parameter int BUS_W = 8,
    localparam int CMP_W = 2 * BUS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             at_top,
    input  logic             at_bottom,
    input  logic [1:0]       upd_mode,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [BUS_W-1:0] wr_data,
    output logic [CMP_W-1:0] active_o,
    output logic             ien_o
);
    logic [BUS_W-1:0] temp_q;
    logic [CMP_W-1:0] buf_q;
    logic [CMP_W-1:0] active_q;
    upd_mode_e        mode_q;
    logic             commit;
    logic             is_direct;
    logic             load_now;

    // Decode the commit strobe and the buffered load condition.
    always_comb begin
        commit    = wr_en && (wr_sel == ADR_LO);
        is_direct = (mode_q != UPD_AT_TOP) && (mode_q != UPD_AT_BOTTOM);
        load_now  = tick_en && (((mode_q == UPD_AT_TOP) && at_top) ||
                                ((mode_q == UPD_AT_BOTTOM) && at_bottom));
    end

    // Register the mode so that a change applies from the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= UPD_DIRECT;
        else        mode_q <= upd_mode_e'(upd_mode);
    end

    // Temporary high byte and control enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            temp_q <= '0;
            ien_o  <= 1'b0;
        end else if (wr_en) begin
            if (wr_sel == ADR_HI)   temp_q <= wr_data;
            if (wr_sel == ADR_CTRL) ien_o  <= wr_data[0];
        end
    end

    // The buffer takes every committed 16-bit value.
    always_ff @(posedge clk) begin
        if (!rst_n)      buf_q <= '0;
        else if (commit) buf_q <= {temp_q, wr_data};
    end

    // Active value: direct commit, or a load from the buffer at TOP/BOTTOM.
    always_ff @(posedge clk) begin
        if (!rst_n)                  active_q <= '0;
        else if (is_direct && commit) active_q <= {temp_q, wr_data};
        else if (load_now)           active_q <= buf_q;
    end

    assign active_o = active_q;

    // R7: a buffered-at-TOP channel keeps its value between TOP ticks
    p_hold_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == UPD_AT_TOP && !(tick_en && at_top)) |=> $stable(active_q));

    // R8: a BOTTOM tick loads the previous buffer contents
    p_bottom_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == UPD_AT_BOTTOM && tick_en && at_bottom) |=> (active_q == $past(buf_q)));

    // R9: a direct-mode commit is visible after one edge
    p_direct_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == UPD_DIRECT && commit) |=> (active_q == $past({temp_q, wr_data})));
endmodule

// File: rtl/ocu_flag.sv
// Sticky compare flag with tick-qualified set, acknowledge and software clear,
// and interrupt request gating. Set takes priority over clear.
// Assumes synchronous active-low reset.
module ocu_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic match_i,
    input  logic irq_ack,
    input  logic sw_clr,
    input  logic ien_i,
    output logic flag_o,
    output logic irq_o
);
    logic set_ev;
    logic clr_ev;

    // Set and clear events for this cycle.
    always_comb begin
        set_ev = tick_en && match_i;
        clr_ev = irq_ack || sw_clr;
    end

    // Flag register, set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_o <= 1'b0;
        else if (set_ev) flag_o <= 1'b1;
        else if (clr_ev) flag_o <= 1'b0;
    end

    // Interrupt request gated by the enable.
    always_comb begin
        irq_o = flag_o && ien_i;
    end

    // R2: a ticked match sets the flag after one edge
    p_flag_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        set_ev |=> flag_o);

    // R2: with no ticked match a clear flag stays clear
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_ev && !flag_o) |=> !flag_o);

    // R4, R5: a clear without a competing set empties the flag
    p_flag_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ev && !set_ev) |=> !flag_o);
endmodule

// File: rtl/ocu_channel.sv
// Top of the compare channel: register file, comparator and flag logic.
// Assumes the counter, its TOP/BOTTOM strobes and tick enable are driven externally.
module ocu_channel
    import ocu_pkg::*;
#(
    parameter int BUS_W = 8,
    localparam int CMP_W = 2 * BUS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic [CMP_W-1:0] cnt_val,
    input  logic             at_top,
    input  logic             at_bottom,
    input  logic [1:0]       upd_mode,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [BUS_W-1:0] wr_data,
    input  logic             irq_ack,
    output logic             match_o,
    output logic             flag_o,
    output logic             irq_o,
    output logic [CMP_W-1:0] top_val_o
);
    logic [CMP_W-1:0] active;
    logic             ien;
    logic             sw_clr;

    // Software clear strobe: write one to bit 0 of the flag address.
    always_comb begin
        sw_clr = wr_en && (wr_sel == ADR_FLAG) && wr_data[0];
    end

    ocu_regfile #(.BUS_W(BUS_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .at_top(at_top), .at_bottom(at_bottom), .upd_mode(upd_mode),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .active_o(active), .ien_o(ien)
    );

    ocu_compare #(.CMP_W(CMP_W)) u_cmp (
        .cnt_i(cnt_val), .ref_i(active), .eq_o(match_o)
    );

    ocu_flag u_flag (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .match_i(match_o),
        .irq_ack(irq_ack), .sw_clr(sw_clr), .ien_i(ien),
        .flag_o(flag_o), .irq_o(irq_o)
    );

    assign top_val_o = active;

    // R1: a match only ever reports equal operands
    p_match_eq_r1: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> (cnt_val == top_val_o));

    // R3: no interrupt request without a set flag
    p_irq_needs_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> flag_o);

    // R6: set and clear together leave the flag set
    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && match_o && (irq_ack || sw_clr)) |=> flag_o);
endmodule

// File: tb/test_ocu_channel.sv
// Scoreboard bench: the driver queues expected values with a due cycle,
// and the monitor compares them at the falling edge of that cycle.
module test_ocu_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [15:0] cnt_val = '0;
    logic        at_top = 1'b0;
    logic        at_bottom = 1'b0;
    logic [1:0]  upd_mode = 2'd0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [7:0]  wr_data = '0;
    logic        irq_ack = 1'b0;
    logic        match_o, flag_o, irq_o;
    logic [15:0] top_val_o;

    ocu_channel i_ocu_channel (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_val(cnt_val),
        .at_top(at_top), .at_bottom(at_bottom), .upd_mode(upd_mode),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .irq_ack(irq_ack),
        .match_o(match_o), .flag_o(flag_o), .irq_o(irq_o), .top_val_o(top_val_o)
    );

    always #10 clk = ~clk;

    typedef enum int {F_MATCH, F_FLAG, F_IRQ, F_TOP} fld_e;
    typedef struct {
        int          due;
        fld_e        fld;
        logic [15:0] val;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_total = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic push(int due, fld_e f, logic [15:0] v, string tag);
        exp_t e;
        e.due = due; e.fld = f; e.val = v; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic exp_now(fld_e f, logic [15:0] v, string tag);
        push(cyc, f, v, tag);
    endtask

    task automatic exp_next(fld_e f, logic [15:0] v, string tag);
        push(cyc + 1, f, v, tag);
    endtask

    task automatic set_wr(logic [1:0] a, logic [7:0] d);
        wr_en = 1'b1; wr_sel = a; wr_data = d;
    endtask

    // Monitor: pop every item due by this cycle and compare.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            exp_t e;
            logic [15:0] act;
            e = q.pop_front();
            case (e.fld)
                F_MATCH: act = {15'd0, match_o};
                F_FLAG:  act = {15'd0, flag_o};
                F_IRQ:   act = {15'd0, irq_o};
                default: act = top_val_o;
            endcase
            n_total++;
            if (act !== e.val) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", e.tag, act, e.val);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (10000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        // R12 reset state
        step(); step(); step();
        exp_now(F_FLAG, 16'd0, "R12 reset flag");
        exp_now(F_TOP, 16'd0, "R12 reset active");
        exp_now(F_IRQ, 16'd0, "R12 reset irq");
        rst_n = 1'b1;
        step();

        // R10, R9: direct mode 16-bit write
        set_wr(2'd1, 8'h12);
        step();
        set_wr(2'd0, 8'h34);
        exp_now(F_TOP, 16'h0000, "R10 high byte alone");
        exp_next(F_TOP, 16'h1234, "R9 direct commit");
        step();
        wr_en = 1'b0;
        exp_now(F_TOP, 16'h1234, "R11 top value");

        // R1, R2: match and tick-qualified set
        cnt_val = 16'h1234; tick_en = 1'b0;
        exp_now(F_MATCH, 16'd1, "R1 equal");
        exp_next(F_FLAG, 16'd0, "R2 no tick");
        step();
        tick_en = 1'b1;
        exp_next(F_FLAG, 16'd1, "R2 ticked match");
        step();
        tick_en = 1'b0; cnt_val = 16'h0000;
        exp_now(F_MATCH, 16'd0, "R1 not equal");

        // R3: interrupt enable
        exp_now(F_IRQ, 16'd0, "R3 disabled");
        set_wr(2'd3, 8'h01);
        exp_next(F_IRQ, 16'd1, "R3 enabled");
        step();

        // R5: software clear
        set_wr(2'd2, 8'h00);
        exp_next(F_FLAG, 16'd1, "R5 write zero ignored");
        step();
        set_wr(2'd2, 8'h01);
        exp_next(F_FLAG, 16'd0, "R5 write one clears");
        exp_next(F_IRQ, 16'd0, "R3 irq drops");
        step();
        wr_en = 1'b0;

        // R4: acknowledge clear
        cnt_val = 16'h1234; tick_en = 1'b1;
        step();
        tick_en = 1'b0; cnt_val = 16'h0000;
        exp_now(F_FLAG, 16'd1, "R4 flag set before ack");
        irq_ack = 1'b1;
        exp_next(F_FLAG, 16'd0, "R4 ack clears");
        step();

        // R6: set wins over simultaneous clear
        cnt_val = 16'h1234; tick_en = 1'b1; irq_ack = 1'b1;
        exp_next(F_FLAG, 16'd1, "R6 set wins");
        step();
        tick_en = 1'b0; cnt_val = 16'h0000;
        exp_next(F_FLAG, 16'd0, "R4 ack clears again");
        step();
        irq_ack = 1'b0;

        // R12: mode change applies from the next cycle
        set_wr(2'd1, 8'h55);
        step();
        set_wr(2'd0, 8'h66); upd_mode = 2'd1;
        exp_next(F_TOP, 16'h5566, "R12 old mode still direct");
        step();

        // R7: update at TOP
        set_wr(2'd1, 8'hAB);
        step();
        set_wr(2'd0, 8'hCD);
        exp_next(F_TOP, 16'h5566, "R7 write buffered");
        step();
        wr_en = 1'b0;
        tick_en = 1'b1; at_bottom = 1'b1;
        exp_next(F_TOP, 16'h5566, "R7 bottom ignored");
        step();
        tick_en = 1'b0; at_bottom = 1'b0; at_top = 1'b1;
        exp_next(F_TOP, 16'h5566, "R7 top without tick");
        step();
        tick_en = 1'b1;
        exp_next(F_TOP, 16'hABCD, "R7 load at top");
        step();
        tick_en = 1'b0; at_top = 1'b0;

        // R8: update at BOTTOM
        upd_mode = 2'd2;
        step();
        set_wr(2'd1, 8'h0F);
        step();
        set_wr(2'd0, 8'h0E);
        exp_next(F_TOP, 16'hABCD, "R8 write buffered");
        step();
        wr_en = 1'b0;
        tick_en = 1'b1; at_top = 1'b1;
        exp_next(F_TOP, 16'hABCD, "R8 top ignored");
        step();
        at_top = 1'b0; at_bottom = 1'b1;
        exp_next(F_TOP, 16'h0F0E, "R8 load at bottom");
        step();
        tick_en = 1'b0; at_bottom = 1'b0;
        cnt_val = 16'h0F0E;
        exp_now(F_MATCH, 16'd1, "R1 match on loaded value");
        step(); step(); step();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule